// File: doc/BRIEF.md
# Miss Load Queue with Non-blocking Prefetch

This block queues memory operations that missed the first-level data cache and walks them, one at a time and strictly oldest first, through an external-cache lookup. Each entry is either a load, which carries a destination register tag and must deliver data, or a prefetch, which only warms the external cache and never produces register data. Prefetches come in two kinds: one prepares a block for reading and the other prepares it for writing.

A load that misses the external cache sends a miss request, then holds the head of the queue until its fill returns. Nothing behind it is looked up in that time. A prefetch is handled differently. It leaves the queue as soon as its lookup completes, whether it hit or missed. On a miss it hands the request to the miss tracker in the same cycle that it retires. A prefetch miss therefore never holds up the entries behind it.

Top module: `lbuf_pf_queue`

## Requirements
- R1: The queue holds DEPTH (default 9) entries. `full` is high exactly when all entries are occupied. An `enq_valid` pulse while `full` is high is dropped and never reaches the lookup port.
- R2: Only the oldest entry is presented on the lookup port (`lk_valid`, `lk_addr`). Entries are looked up and retired in enqueue order. Lookup and retire are never active in the same cycle.
- R3: A load whose lookup completes with `lk_hit`=1 retires in the next cycle. On retire, `ret_wen`=1, `ret_data` carries the lookup data and `ret_tag` carries its tag.
- R4: A load whose lookup misses raises `mreq_valid` with `mreq_own`=0 and its address, and holds the request until `mreq_ready`. It then blocks the queue: there is no lookup and no retire until a fill returns.
- R5: When `fill_valid` arrives for a blocked load, the load retires in the next cycle with `ret_wen`=1 and `ret_data` equal to the fill data.
- R6: A prefetch whose lookup hits retires in the next cycle with `ret_is_pf`=1, `ret_wen`=0 and `ret_data`=0, and raises no miss request.
- R7: A prefetch whose lookup misses raises `mreq_valid` with `mreq_own` equal to its write-kind flag (1 = prepare for writing, 0 = for reading). `ret_valid` is high in the same cycle in which `mreq_ready` is high and not before. No fill is awaited.
- R8: `lk_done` while `lk_valid` is low, and `fill_valid` while no load is waiting on memory, have no effect on the queue or its outputs.
- R9: After reset the queue is empty: `full`, `lk_valid`, `mreq_valid` and `ret_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue a missed operation |
| enq_is_pf | input | 1 | 1 = prefetch, 0 = load |
| enq_pf_write | input | 1 | Prefetch kind: 1 = for writing |
| enq_addr | input | ADDR_W | Block address |
| enq_tag | input | TAG_W | Destination register tag |
| full | output | 1 | All entries occupied |
| lk_valid | output | 1 | Lookup request for head entry |
| lk_addr | output | ADDR_W | Lookup address |
| lk_done | input | 1 | Lookup completes this cycle |
| lk_hit | input | 1 | Lookup result is a hit |
| lk_data | input | DATA_W | Data from a hitting lookup |
| mreq_valid | output | 1 | Miss request to tracker |
| mreq_addr | output | ADDR_W | Miss request address |
| mreq_own | output | 1 | 1 = ownership request, 0 = shared read |
| mreq_ready | input | 1 | Tracker accepts request |
| fill_valid | input | 1 | Fill returns for the waiting load |
| fill_data | input | DATA_W | Fill data |
| ret_valid | output | 1 | Head entry retires |
| ret_is_pf | output | 1 | Retiring entry is a prefetch |
| ret_wen | output | 1 | Register write enable |
| ret_tag | output | TAG_W | Destination register tag |
| ret_data | output | DATA_W | Load result data |

## Verification
The bench builds the block with DEPTH=9, ADDR_W=16, DATA_W=32 and TAG_W=5. At nine entries the queue is filled and held at capacity while a further enqueue is attempted. The nine stimulus rows then mix load and prefetch hits and misses of both prefetch kinds. A load miss then sits at the head with younger entries behind it, so the blocking is seen with real waiters. The same setting lets a prefetch miss retire under tracker backpressure.

// File: rtl/lbq_pkg.sv
package lbq_pkg;

   typedef enum logic [2:0] {
      HS_LOOK  = 3'd0,
      HS_RET   = 3'd1,
      HS_LDREQ = 3'd2,
      HS_FILL  = 3'd3,
      HS_PFREQ = 3'd4
   } head_st_e;

endpackage

// File: rtl/lbq_fifo.sv
module lbq_fifo #(
   parameter int DEPTH = 9,
   parameter int WIDTH = 23,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output logic [CW-1:0]    occ
);

   localparam bit POW2 = (DEPTH == (1 << PW));

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign occ     = cnt;
   assign dout    = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_natural
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_compare
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

endmodule

// File: rtl/lbq_head_ctl.sv
module lbq_head_ctl
   import lbq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_valid,
   input  logic              head_pf,
   input  logic              head_pfw,
   input  logic              lk_done,
   input  logic              lk_hit,
   input  logic [DATA_W-1:0] lk_data,
   input  logic              mreq_ready,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   output logic              lk_valid,
   output logic              mreq_valid,
   output logic              mreq_own,
   output logic              ret_valid,
   output logic              ret_wen,
   output logic [DATA_W-1:0] ret_data,
   output logic              pop
);

   head_st_e          st, st_nxt;
   logic [DATA_W-1:0] hold_q;

   assign lk_valid = (st == HS_LOOK) && head_valid;

   always_comb begin
      st_nxt     = st;
      mreq_valid = 1'b0;
      mreq_own   = 1'b0;
      ret_valid  = 1'b0;
      pop        = 1'b0;
      unique case (st)
         HS_LOOK: begin
            if (lk_valid && lk_done) begin
               if (lk_hit)       st_nxt = HS_RET;
               else if (head_pf) st_nxt = HS_PFREQ;
               else              st_nxt = HS_LDREQ;
            end
         end
         HS_RET: begin
            ret_valid = 1'b1;
            pop       = 1'b1;
            st_nxt    = HS_LOOK;
         end
         HS_LDREQ: begin
            mreq_valid = 1'b1;
            if (mreq_ready) st_nxt = HS_FILL;
         end
         HS_FILL: begin
            if (fill_valid) st_nxt = HS_RET;
         end
         HS_PFREQ: begin
            mreq_valid = 1'b1;
            mreq_own   = head_pfw;
            ret_valid  = mreq_ready;
            pop        = mreq_ready;
            if (mreq_ready) st_nxt = HS_LOOK;
         end
         default: st_nxt = HS_LOOK;
      endcase
   end

   assign ret_wen  = ret_valid && !head_pf;
   assign ret_data = head_pf ? '0 : hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= HS_LOOK;
         hold_q <= '0;
      end else begin
         st <= st_nxt;
         if (lk_valid && lk_done && lk_hit) hold_q <= lk_data;
         else if (st == HS_FILL && fill_valid) hold_q <= fill_data;
      end
   end

endmodule

// File: rtl/lbuf_pf_queue.sv
module lbuf_pf_queue #(
   parameter int DEPTH  = 9,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic              enq_is_pf,
   input  logic              enq_pf_write,
   input  logic [ADDR_W-1:0] enq_addr,
   input  logic [TAG_W-1:0]  enq_tag,
   output logic              full,
   output logic              lk_valid,
   output logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_done,
   input  logic              lk_hit,
   input  logic [DATA_W-1:0] lk_data,
   output logic              mreq_valid,
   output logic [ADDR_W-1:0] mreq_addr,
   output logic              mreq_own,
   input  logic              mreq_ready,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   output logic              ret_valid,
   output logic              ret_is_pf,
   output logic              ret_wen,
   output logic [TAG_W-1:0]  ret_tag,
   output logic [DATA_W-1:0] ret_data
);

   localparam int ENT_W = 2 + TAG_W + ADDR_W;
   localparam int CW    = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         initial $fatal(1, "lbuf_pf_queue: DEPTH must be at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 1 || TAG_W < 1) begin : g_bad_width
         initial $fatal(1, "lbuf_pf_queue: widths must be positive");
      end
   endgenerate

   logic [ENT_W-1:0]  head_ent;
   logic              q_empty, pop;
   logic [CW-1:0]     occ;
   logic              head_pf, head_pfw;
   logic [TAG_W-1:0]  head_tag;
   logic [ADDR_W-1:0] head_addr;

   lbq_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (enq_valid),
      .din   ({enq_is_pf, enq_pf_write, enq_tag, enq_addr}),
      .pop   (pop),
      .dout  (head_ent),
      .empty (q_empty),
      .full  (full),
      .occ   (occ)
   );

   assign {head_pf, head_pfw, head_tag, head_addr} = head_ent;

   lbq_head_ctl #(.DATA_W(DATA_W)) u_head (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (!q_empty),
      .head_pf    (head_pf),
      .head_pfw   (head_pfw),
      .lk_done    (lk_done),
      .lk_hit     (lk_hit),
      .lk_data    (lk_data),
      .mreq_ready (mreq_ready),
      .fill_valid (fill_valid),
      .fill_data  (fill_data),
      .lk_valid   (lk_valid),
      .mreq_valid (mreq_valid),
      .mreq_own   (mreq_own),
      .ret_valid  (ret_valid),
      .ret_wen    (ret_wen),
      .ret_data   (ret_data),
      .pop        (pop)
   );

   assign lk_addr   = head_addr;
   assign mreq_addr = head_addr;
   assign ret_is_pf = head_pf;
   assign ret_tag   = head_tag;

endmodule

// File: rtl/lbq_checker.sv
module lbq_checker #(
   parameter int DEPTH  = 9,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enq_valid,
   input logic              full,
   input logic [CW-1:0]     occ,
   input logic              lk_valid,
   input logic              mreq_valid,
   input logic              mreq_ready,
   input logic [ADDR_W-1:0] mreq_addr,
   input logic              ret_valid,
   input logic              ret_is_pf,
   input logic              ret_wen,
   input logic [DATA_W-1:0] ret_data
);

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !ret_valid) |=> (occ == CW'(DEPTH)));

   assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));

   assert_look_or_retire_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> !ret_valid);

   assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));

   assert_load_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ret_wen |-> (ret_valid && !ret_is_pf));

   assert_pf_no_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ret_is_pf) |-> (!ret_wen && ret_data == '0));

   assert_pf_miss_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && mreq_valid) |-> (mreq_ready && ret_is_pf));

   assert_push_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && !full && !ret_valid) |=> (occ == $past(occ) + 1'b1));

endmodule

bind lbuf_pf_queue lbq_checker #(
   .DEPTH (DEPTH),
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) i_lbq_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .enq_valid  (enq_valid),
   .full       (full),
   .occ        (occ),
   .lk_valid   (lk_valid),
   .mreq_valid (mreq_valid),
   .mreq_ready (mreq_ready),
   .mreq_addr  (mreq_addr),
   .ret_valid  (ret_valid),
   .ret_is_pf  (ret_is_pf),
   .ret_wen    (ret_wen),
   .ret_data   (ret_data)
);

// File: tb/test_lbuf_pf_queue.sv
module test_lbuf_pf_queue;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 9;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int TAG_W  = 5;
   localparam int ROWS   = 9;
   localparam int WDOG   = 20000;

   // row layout: {is_pf, pf_write, hit, tag[4:0], addr[15:0], data[31:0]}
   localparam logic [55:0] VEC [ROWS] = '{
      {1'b0, 1'b0, 1'b1, 5'd1,  16'h0100, 32'hA1A1_0001},
      {1'b0, 1'b0, 1'b0, 5'd2,  16'h0140, 32'hB2B2_0002},
      {1'b1, 1'b0, 1'b0, 5'd3,  16'h0180, 32'hC3C3_0003},
      {1'b0, 1'b0, 1'b1, 5'd4,  16'h01C0, 32'hD4D4_0004},
      {1'b1, 1'b1, 1'b1, 5'd5,  16'h0200, 32'hE5E5_0005},
      {1'b1, 1'b1, 1'b0, 5'd6,  16'h0240, 32'hF6F6_0006},
      {1'b0, 1'b0, 1'b0, 5'd7,  16'h0280, 32'h1717_0007},
      {1'b1, 1'b0, 1'b1, 5'd8,  16'h02C0, 32'h2828_0008},
      {1'b0, 1'b0, 1'b1, 5'd9,  16'h0300, 32'h3939_0009}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enq_valid = 1'b0, enq_is_pf = 1'b0, enq_pf_write = 1'b0;
   logic [ADDR_W-1:0] enq_addr = '0;
   logic [TAG_W-1:0]  enq_tag = '0;
   logic              full, lk_valid, mreq_valid, mreq_own;
   logic [ADDR_W-1:0] lk_addr, mreq_addr;
   logic              lk_done = 1'b0, lk_hit = 1'b0;
   logic [DATA_W-1:0] lk_data = '0;
   logic              mreq_ready = 1'b0;
   logic              fill_valid = 1'b0;
   logic [DATA_W-1:0] fill_data = '0;
   logic              ret_valid, ret_is_pf, ret_wen;
   logic [TAG_W-1:0]  ret_tag;
   logic [DATA_W-1:0] ret_data;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lbuf_pf_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W))
   i_lbuf_pf_queue (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_is_pf(enq_is_pf), .enq_pf_write(enq_pf_write),
      .enq_addr(enq_addr), .enq_tag(enq_tag), .full(full),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_done(lk_done), .lk_hit(lk_hit),
      .lk_data(lk_data), .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
      .mreq_own(mreq_own), .mreq_ready(mreq_ready), .fill_valid(fill_valid),
      .fill_data(fill_data), .ret_valid(ret_valid), .ret_is_pf(ret_is_pf),
      .ret_wen(ret_wen), .ret_tag(ret_tag), .ret_data(ret_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic serve(input logic [55:0] v);
      logic pf, pfw, hit;
      logic [TAG_W-1:0]  tag;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
      {pf, pfw, hit, tag, addr, data} = v;
      while (!lk_valid) step();
      chk(lk_addr == addr, "R2", "lookup order addr", 64'(lk_addr), 64'(addr));
      chk(!ret_valid, "R2", "retire during lookup", 64'(ret_valid), 64'd0);
      lk_done = 1'b1; lk_hit = hit; lk_data = data;
      step();
      lk_done = 1'b0; lk_hit = 1'b0; lk_data = '0;
      #1;
      if (hit) begin
         if (pf) begin
            chk(ret_valid && ret_is_pf && !ret_wen && ret_data == '0 && !mreq_valid,
                "R6", "prefetch hit retire", 64'({ret_valid, ret_is_pf, ret_wen, mreq_valid}),
                64'b1100);
         end else begin
            chk(ret_valid && ret_wen && !ret_is_pf, "R3", "load hit retire",
                64'({ret_valid, ret_wen}), 64'b11);
            chk(ret_data == data && ret_tag == tag, "R3", "load hit data/tag",
                64'({ret_tag, ret_data}), 64'({tag, data}));
         end
         step();
      end else if (pf) begin
         chk(mreq_valid && mreq_own == pfw && mreq_addr == addr, "R7", "prefetch miss request",
             64'({mreq_valid, mreq_own, mreq_addr}), 64'({1'b1, pfw, addr}));
         chk(!ret_valid, "R7", "retire before tracker ready", 64'(ret_valid), 64'd0);
         step();
         chk(mreq_valid && !ret_valid, "R7", "request held under backpressure",
             64'({mreq_valid, ret_valid}), 64'b10);
         mreq_ready = 1'b1;
         #1;
         chk(ret_valid && ret_is_pf && !ret_wen, "R7", "retire with handoff",
             64'({ret_valid, ret_is_pf, ret_wen}), 64'b110);
         step();
         mreq_ready = 1'b0;
      end else begin
         chk(mreq_valid && !mreq_own && mreq_addr == addr, "R4", "load miss request",
             64'({mreq_valid, mreq_own, mreq_addr}), 64'({1'b1, 1'b0, addr}));
         step();
         chk(mreq_valid && !ret_valid, "R4", "load request held",
             64'({mreq_valid, ret_valid}), 64'b10);
         mreq_ready = 1'b1;
         step();
         mreq_ready = 1'b0;
         for (int w = 0; w < 3; w++) begin
            lk_done = 1'b1; lk_hit = 1'b1; lk_data = 32'hDEAD_BEEF;  // R8 stray lookup result
            #1;
            chk(!lk_valid && !ret_valid && !mreq_valid, "R4", "queue blocked on load miss",
                64'({lk_valid, ret_valid, mreq_valid}), 64'b000);
            step();
         end
         lk_done = 1'b0; lk_hit = 1'b0; lk_data = '0;
         fill_valid = 1'b1; fill_data = data;
         #1;
         chk(!ret_valid, "R5", "no retire in fill cycle", 64'(ret_valid), 64'd0);
         step();
         fill_valid = 1'b0; fill_data = '0;
         #1;
         chk(ret_valid && ret_wen && ret_data == data && ret_tag == tag, "R5",
             "retire after fill", 64'({ret_valid, ret_wen, ret_tag, ret_data}),
             64'({1'b1, 1'b1, tag, data}));
         chk(ret_data != 32'hDEAD_BEEF, "R8", "stray lookup data ignored",
             64'(ret_data), 64'(data));
         step();
      end
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", WDOG, WDOG);
      finish_run();
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      #1;
      chk(!full && !lk_valid && !mreq_valid && !ret_valid, "R9", "reset state",
          64'({full, lk_valid, mreq_valid, ret_valid}), 64'b0000);

      // stray responses on an empty queue
      lk_done = 1'b1; lk_hit = 1'b1; fill_valid = 1'b1; fill_data = 32'h5555_5555;
      step();
      lk_done = 1'b0; lk_hit = 1'b0; fill_valid = 1'b0; fill_data = '0;
      repeat (2) begin
         #1;
         chk(!ret_valid && !lk_valid && !mreq_valid, "R8", "stray inputs while empty",
             64'({ret_valid, lk_valid, mreq_valid}), 64'b000);
         step();
      end

      // fill the queue from the vector table
      for (int i = 0; i < ROWS; i++) begin
         #1;
         chk(!full, "R1", "not full before entry", 64'(full), 64'd0);
         {enq_is_pf, enq_pf_write} = VEC[i][55:54];
         enq_tag  = VEC[i][52:48];
         enq_addr = VEC[i][47:32];
         enq_valid = 1'b1;
         step();
         enq_valid = 1'b0;
      end
      #1;
      chk(full, "R1", "full after DEPTH entries", 64'(full), 64'd1);

      // refused enqueue while full
      enq_valid = 1'b1; enq_is_pf = 1'b0; enq_addr = 16'hBAD0; enq_tag = 5'd31;
      step();
      enq_valid = 1'b0;
      #1;
      chk(full, "R1", "still full after refused push", 64'(full), 64'd1);

      for (int i = 0; i < ROWS; i++) serve(VEC[i]);

      repeat (3) begin
         #1;
         chk(!lk_valid && !ret_valid && !full, "R1", "refused entry never looked up",
             64'({lk_valid, ret_valid, full}), 64'b000);
         step();
      end

      finish_run();
   end

endmodule